// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one general-purpose I/O port of `N_PINS` pins through a small register bus. Each pin has four settings: an output latch, a direction bit, an open-drain enable and an analog select. From these the block drives each pad's output-enable and output-data lines. It samples the resolved pad levels through an input register chain and returns the sampled port value when software reads it.

A pin whose direction bit is 0 drives its latch value onto the pad. With open-drain enabled, the pin pulls low for a latch value of 0 and releases the pad for a latch value of 1, so an external pull-up or another driver sets the level. Pins marked analog read as zero at the port address, whatever level is on the pad. Only the lowest `ANALOG_PINS` pins can be marked analog, and after reset all of them are. The bus is a single write strobe with an address. Read data is combinational from the address.

The sampled port value lags the pads by `SYNC_STAGES` clock edges. With the default of one stage, a port read in the cycle right after a write or a direction change still shows the old pin state. The new state appears one cycle later.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, the direction register reads all ones (every pin an input), the latch and open-drain registers read zero, the analog register reads the capability mask (0x3F for the defaults: pins 0 to 5), and every pad output-enable is low.
- R2: Register addresses are 0 = port value, 1 = latch, 2 = direction, 3 = open-drain, 4 = analog select. A write is taken at the rising clock edge where `bus_wr` is high. A write to address 0 or address 1 loads the latch. Read data follows `bus_addr` in the same cycle.
- R3: A pin with direction bit 1 has its pad output-enable low. A pin with direction bit 0 and open-drain bit 0 has output-enable high and pad output equal to its latch bit.
- R4: A pin with direction bit 0 and open-drain bit 1 drives its pad low with output-enable high when its latch bit is 0. When its latch bit is 1 it deasserts output-enable, and the port read returns the externally resolved level.
- R5: A port read (address 0) returns 0 in every bit whose analog-select bit is 1, regardless of the pad level.
- R6: Analog-select bits at or above `ANALOG_PINS` cannot be set. Writes to them are ignored and they read 0.
- R7: A latch read (address 1) returns the latch contents, not the pad level.
- R8: A port read in the cycle after a write that changes pad levels returns the old pin state, and a read one cycle later returns the new state. An external pad change is likewise seen by the port read after one clock edge.
- R9: Writes to addresses 5 to 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data for `bus_addr` (combinational) |
| pad_in | input | N_PINS | Resolved pad levels |
| pad_oe | output | N_PINS | Pad output-enable, one per pin |
| pad_out | output | N_PINS | Pad output data, one per pin |

## Verification
A wrong direction, open-drain or latch bit appears on `pad_oe` and `pad_out` in the cycle after the write that caused it, and as a wrong value when that register is read back. A fault in the input chain appears only as a port value that is shifted by a cycle or keeps a stale value. For that reason the bench compares the port read in the first and second cycles after every pad-changing write. A wrong analog mask leaks pad levels into the port read, but only while the pad differs from zero, so the bench drives external highs onto the analog pins.

// File: rtl/gpio_pkg.sv
// Package: shared register address map for the GPIO port controller.
// Assumes: a 3-bit register address; unused codes decode to "none".
package gpio_pkg;

    localparam int unsigned GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        GREG_PORT   = 3'd0,
        GREG_LATCH  = 3'd1,
        GREG_DIR    = 3'd2,
        GREG_ODRAIN = 3'd3,
        GREG_ANSEL  = 3'd4
    } gpio_reg_e;

endpackage

// File: rtl/gpio_regs.sv
// Module: per-pin configuration registers (latch, direction, open-drain,
// analog select) loaded from the write bus.
// Assumes: synchronous active-low reset; ANA_MASK marks the pins that can
// be analog, and analog bits outside it are held at zero.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned            N_PINS   = 8,
    parameter logic [N_PINS-1:0]      ANA_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [GPIO_ADDR_W-1:0]  addr,
    input  logic [N_PINS-1:0]       wdata,
    output logic [N_PINS-1:0]       lat_q,
    output logic [N_PINS-1:0]       dir_q,
    output logic [N_PINS-1:0]       od_q,
    output logic [N_PINS-1:0]       ana_q
);

    gpio_reg_e sel;

    // Decode the bus address into a register selector.
    always_comb begin
        sel = gpio_reg_e'(addr);
    end

    // Reset to the defaults, or load the addressed register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '1;
            od_q  <= '0;
            ana_q <= ANA_MASK;
        end else if (wr) begin
            case (sel)
                GREG_PORT,
                GREG_LATCH:  lat_q <= wdata;
                GREG_DIR:    dir_q <= wdata;
                GREG_ODRAIN: od_q  <= wdata;
                GREG_ANSEL:  ana_q <= wdata & ANA_MASK;
                default: ;
            endcase
        end
    end

    // R2: a direction write is seen on the next cycle.
    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == GREG_DIR) |=> (dir_q == $past(wdata)));

    // R9: without a write, or with an unmapped address, nothing changes.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || addr > GREG_ANSEL) |=>
            ($stable(lat_q) && $stable(dir_q) && $stable(od_q) && $stable(ana_q)));

    // R6: analog bits outside the capable set are never set.
    p_ana_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_q & ~ANA_MASK) == '0);

endmodule

// File: rtl/gpio_pad_drv.sv
// Module: per-pin pad driver; turns latch, direction and open-drain bits
// into pad output-enable and output data.
// Assumes: direction 1 = input; open-drain pins only ever drive low.
module gpio_pad_drv #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] lat,
    input  logic [N_PINS-1:0] dir,
    input  logic [N_PINS-1:0] od,
    output logic [N_PINS-1:0] oe,
    output logic [N_PINS-1:0] dout
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // Drive enable: outputs drive unless open-drain with latch high.
        always_comb begin
            oe[i]   = !dir[i] && (!od[i] || !lat[i]);
            dout[i] = lat[i] && !od[i];
        end
    end

    // R3: an input pin never drives its pad.
    p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & dir) == '0);

    // R4: an open-drain pin never drives a high level.
    p_od_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & od & dout) == '0);

endmodule

// File: rtl/gpio_in_sync.sv
// Module: input sampling chain of STAGES registers per pin.
// Assumes: STAGES >= 1; each stage resets to zero.
module gpio_in_sync #(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] d,
    output logic [N_PINS-1:0] q
);

    logic [N_PINS-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    // R8: the first stage holds the pad levels from the previous edge.
    p_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stg[0] == $past(d)));

endmodule

// File: rtl/gpio_port.sv
// Module: GPIO port controller top. Holds the per-pin registers, drives
// the pads, samples the pad inputs and returns register or port reads.
// Assumes: read data is combinational from bus_addr; the lowest
// ANALOG_PINS pins can be analog and are analog after reset.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS      = 8,
    parameter int          ANALOG_PINS = 6,
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [2:0]             bus_addr,
    input  logic [N_PINS-1:0]      bus_wdata,
    output logic [N_PINS-1:0]      bus_rdata,
    input  logic [N_PINS-1:0]      pad_in,
    output logic [N_PINS-1:0]      pad_oe,
    output logic [N_PINS-1:0]      pad_out
);

    // Build the analog-capable pin mask from the pin count.
    function automatic logic [N_PINS-1:0] cap_mask();
        logic [N_PINS-1:0] m;
        m = '0;
        for (int i = 0; i < int'(N_PINS); i++) begin
            m[i] = (i < ANALOG_PINS);
        end
        return m;
    endfunction

    localparam logic [N_PINS-1:0] ANA_MASK = cap_mask();

    logic [N_PINS-1:0] lat_q, dir_q, od_q, ana_q, pin_q;

    gpio_regs #(
        .N_PINS   (N_PINS),
        .ANA_MASK (ANA_MASK)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .lat_q (lat_q),
        .dir_q (dir_q),
        .od_q  (od_q),
        .ana_q (ana_q)
    );

    gpio_pad_drv #(
        .N_PINS (N_PINS)
    ) u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .lat   (lat_q),
        .dir   (dir_q),
        .od    (od_q),
        .oe    (pad_oe),
        .dout  (pad_out)
    );

    gpio_in_sync #(
        .N_PINS (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_q)
    );

    // Read mux: the port value hides analog pins; unmapped addresses read 0.
    always_comb begin
        case (gpio_reg_e'(bus_addr))
            GREG_PORT:   bus_rdata = pin_q & ~ana_q;
            GREG_LATCH:  bus_rdata = lat_q;
            GREG_DIR:    bus_rdata = dir_q;
            GREG_ODRAIN: bus_rdata = od_q;
            GREG_ANSEL:  bus_rdata = ana_q;
            default:     bus_rdata = '0;
        endcase
    end

    // R5: a port read never shows a high level on an analog pin.
    p_analog_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == GREG_PORT) |-> ((bus_rdata & ana_q) == '0));

    // R9: unmapped addresses read zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > GREG_ANSEL) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

    localparam int N = 8;
    localparam logic [N-1:0] CAP = 8'h3F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata, pad_in, pad_oe, pad_out;
    logic [N-1:0] ext_en = '0, ext_val = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side model of the requirements.
    logic [N-1:0] m_lat, m_dir, m_od, m_ana, m_pin;

    always #5 clk = ~clk;

    // Resolved pad level: driven pads win, else external driver, else pull-up.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ((ext_en & ext_val) | ~ext_en));

    gpio_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // R8 model: the port value samples the pads once per edge.
    always @(posedge clk) m_pin <= rst_n ? pad_in : '0;

    function automatic logic [N-1:0] exp_oe();
        return ~m_dir & (~m_od | ~m_lat);
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        case (a)
            3'd0, 3'd1: m_lat = d;
            3'd2: m_dir = d;
            3'd3: m_od  = d;
            3'd4: m_ana = d & CAP;
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] v;
        chk({tag, " R3 R4 pad_oe"}, pad_oe, exp_oe());
        chk({tag, " R3 pad_out"}, pad_out & pad_oe, m_lat & ~m_od & exp_oe());
        rd(3'd0, v); chk({tag, " R5 R8 port"}, v, m_pin & ~m_ana);
        rd(3'd1, v); chk({tag, " R7 latch"}, v, m_lat);
        rd(3'd2, v); chk({tag, " R2 dir"}, v, m_dir);
        rd(3'd3, v); chk({tag, " R2 odrain"}, v, m_od);
        rd(3'd4, v); chk({tag, " R6 ansel"}, v, m_ana);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1234));
        m_lat = '0; m_dir = '1; m_od = '0; m_ana = CAP;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state.
        chk("R1 pad_oe", pad_oe, '0);
        rd(3'd1, v); chk("R1 latch", v, '0);
        rd(3'd2, v); chk("R1 dir", v, '1);
        rd(3'd3, v); chk("R1 odrain", v, '0);
        rd(3'd4, v); chk("R1 ansel", v, CAP);

        // R5: pulled-up pads on analog pins read as zero.
        @(posedge clk); #1;
        rd(3'd0, v); chk("R5 analog reads zero", v, 8'hC0);

        // R6: bits above the capable set cannot be set.
        wr(3'd4, 8'hFF);
        rd(3'd4, v); chk("R6 cap mask", v, 8'h3F);
        wr(3'd4, 8'h00);

        // R8: drive all pins low; old value first, new one cycle later.
        @(posedge clk); #1;
        wr(3'd2, 8'h00);
        rd(3'd0, v); chk("R8 old state after dir change", v, 8'hFF);
        @(posedge clk); #1;
        rd(3'd0, v); chk("R8 new state one cycle later", v, 8'h00);

        // R8: latch write timing.
        wr(3'd0, 8'hA5);
        rd(3'd0, v); chk("R8 old state after latch write", v, 8'h00);
        @(posedge clk); #1;
        rd(3'd0, v); chk("R8 new latch state", v, 8'hA5);

        // R4: open-drain, latch high releases; external low pulls down.
        wr(3'd3, 8'hFF);
        chk("R4 od oe", pad_oe, 8'h5A);
        @(negedge clk); ext_en = 8'h0F; ext_val = 8'h00;
        @(posedge clk); #1;
        rd(3'd0, v); chk("R4 od readback", v, 8'hA0);

        // R7: input pins with latch high, pads driven low externally.
        wr(3'd2, 8'hFF);
        @(negedge clk); ext_en = 8'hFF; ext_val = 8'h00;
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R7 latch not pad", v, 8'hFF);
        @(posedge clk); #1;
        rd(3'd0, v); chk("R7 port shows pad", v, 8'h00);

        // R9: unmapped writes change nothing and read zero.
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'h3C);
            rd(3'(a), v); chk("R9 unmapped read", v, '0);
            check_all("R9 no effect");
        end

        // Random mix of writes and external pad activity.
        for (int it = 0; it < 400; it++) begin
            logic [2:0] a;
            a = 3'($urandom % 6);
            @(negedge clk);
            ext_en  = N'($urandom);
            ext_val = N'($urandom);
            wr(a, N'($urandom));
            check_all("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule